// File: doc/BRIEF.md
# LPC Slave Shutdown Controller

This block decides when a Low Pin Count slave interface is held in its shutdown state. Two sources can cause shutdown. The hardware source follows the active-low power-down pin, and only does so once firmware has armed it. The software source is a control bit that firmware sets and clears. While either source is active, or while the LPC reset pin is asserted, the block drives a shutdown-reset output to the rest of the interface. It also forces the interface's other host-side inputs to zero, so that only the two pins it watches itself can still have an effect.

The bits interlock. Arming the hardware source clears the software bit in the same write. A rising edge on the power-down pin disarms the hardware source. A falling edge on the pin latches a sticky flag, and that flag can raise an interrupt request when the interrupt is enabled. Firmware reaches the bits through a one-cycle write/read port. Both pins go through a synchronizer before any level or edge is used. A typical sequence: firmware waits for the flag interrupt, sets the software bit, then arms the hardware source. It then reads back the pin level to confirm the pin has not already risen. If it has, firmware clears the arm bit.

Top module: `lpc_shutdown_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, every control bit and the flag are 0, `shut_rst_o` and `irq_o` are 0, and a read returns 5'b10000 while the power-down pin is high.
- R2: Register bit 1 (software halt) drives `shut_rst_o` high while set. A rising edge on the power-down pin does not clear it. Only a firmware write of 0 clears it.
- R3: A write with bit 0 (hardware arm) set to 1 leaves bit 1 at 0, whatever value bit 1 had in that write.
- R4: While bit 0 is 1, a synchronized low level on the power-down pin puts the block in shutdown. This includes the case where the arm bit was set before the pin fell.
- R5: A synchronized rising edge on the power-down pin clears bit 0 to 0.
- R6: A synchronized falling edge on the power-down pin sets bit 2 (edge flag) to 1, whatever the value of bit 0.
- R7: A write with bit 2 at 0 clears the flag only if a read since the previous write returned the flag as 1. Otherwise the flag stays 1.
- R8: `irq_o` is high one cycle after both the flag (bit 2) and bit 3 (interrupt enable) are 1, and low otherwise.
- R9: Read bit 4 returns the synchronized power-down pin level, where 1 means high.
- R10: While the synchronized LPC reset is asserted, bits 0 to 2 are held at 0, register writes have no effect, and `shut_rst_o` is 1. Bit 3 keeps its value.
- R11: `host_o` follows `host_i` one cycle later, and is all zeros whenever the block is in shutdown.
- R12: A level change on the power-down pin reaches the state after SYNC_STAGES flops. With the default of 2, an armed block raises `shut_rst_o` at the third rising clock edge after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Power-down pin, active low, asynchronous |
| lreset_n_i | input | 1 | LPC reset pin, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 4 | Write data: bit0 arm, bit1 software halt, bit2 flag, bit3 interrupt enable |
| rdata_o | output | 5 | Read data, registered: write fields plus bit4 pin level |
| host_i | input | HOST_W | Other host-side inputs of the interface |
| host_o | output | HOST_W | Host inputs, zeroed during shutdown |
| shut_rst_o | output | 1 | Shutdown reset to the interface |
| irq_o | output | 1 | Error interrupt request |

## Verification
The assertions check, every cycle, the local interlocks. These are: arming clears the software bit, a rising edge disarms, a falling edge sets the flag, the software bit holds when there is no write, the LPC reset forces shutdown, and the host outputs are zero during shutdown. Only the bench scenarios can show the behaviour that spans several cycles. That covers the read-before-clear rule for the flag, the way the software bit survives a pin rise, and the three-edge latency from the pin to the output. It also covers the fact that writes made during LPC reset leave no trace after reset is released.

// File: rtl/lpc_sd_pkg.sv
package lpc_sd_pkg;
  localparam int WR_W = 4;
  localparam int RD_W = 5;
  localparam int F_ARM = 0;
  localparam int F_SWH = 1;
  localparam int F_FLG = 2;
  localparam int F_IEN = 3;
  localparam int F_LVL = 4;
endpackage

// File: rtl/lpc_sd_sync.sv
module lpc_sd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/lpc_sd_edge.sv
module lpc_sd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl_i;
  end

  assign rise_o = ~prev_q & lvl_i;
  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/lpc_sd_regs.sv
module lpc_sd_regs
  import lpc_sd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            lrst_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [WR_W-1:0] wdata_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            lvl_i,
  output logic            arm_o,
  output logic            swh_o,
  output logic            flg_o,
  output logic            ien_o,
  output logic [RD_W-1:0] rdata_o
);
  logic rd_seen_q;

  // hardware arm: rising edge wins over a write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || lrst_i)  arm_o <= 1'b0;
    else if (rise_i)    arm_o <= 1'b0;
    else if (wr_en_i)   arm_o <= wdata_i[F_ARM];
  end

  // software halt: arming clears it; the pin does not touch it
  always_ff @(posedge clk) begin
    if (rst || lrst_i) swh_o <= 1'b0;
    else if (wr_en_i)  swh_o <= wdata_i[F_SWH] & ~wdata_i[F_ARM];
  end

  // sticky edge flag with read-then-clear protocol
  always_ff @(posedge clk) begin
    if (rst || lrst_i) flg_o <= 1'b0;
    else if (fall_i)   flg_o <= 1'b1;
    else if (wr_en_i && !wdata_i[F_FLG] && rd_seen_q) flg_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || lrst_i)          rd_seen_q <= 1'b0;
    else if (wr_en_i)           rd_seen_q <= 1'b0;
    else if (rd_en_i && flg_o)  rd_seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     ien_o <= 1'b0;
    else if (wr_en_i && !lrst_i) ien_o <= wdata_i[F_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_en_i) begin
      rdata_o[F_ARM] <= arm_o;
      rdata_o[F_SWH] <= swh_o;
      rdata_o[F_FLG] <= flg_o;
      rdata_o[F_IEN] <= ien_o;
      rdata_o[F_LVL] <= lvl_i;
    end
  end

  assert_arm_clears_sw_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wdata_i[F_ARM]) |=> !swh_o);
  assert_rise_disarms_R5: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> !arm_o);
  assert_fall_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !lrst_i) |=> flg_o);
  assert_sw_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (swh_o && !wr_en_i && !lrst_i) |=> swh_o);
endmodule

// File: rtl/lpc_shutdown_ctrl.sv
module lpc_shutdown_ctrl
  import lpc_sd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n_i,
  input  logic              lreset_n_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WR_W-1:0]   wdata_i,
  output logic [RD_W-1:0]   rdata_o,
  input  logic [HOST_W-1:0] host_i,
  output logic [HOST_W-1:0] host_o,
  output logic              shut_rst_o,
  output logic              irq_o
);
  logic [1:0] pins_s;
  logic pd_lvl, lrst_act, pd_rise, pd_fall;
  logic arm, swh, flg, ien, shut_c;

  lpc_sd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d_i({lreset_n_i, pd_n_i}), .q_o(pins_s));

  assign pd_lvl   = pins_s[0];
  assign lrst_act = ~pins_s[1];

  lpc_sd_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(pd_lvl), .rise_o(pd_rise), .fall_o(pd_fall));

  lpc_sd_regs u_regs (
    .clk(clk), .rst(rst), .lrst_i(lrst_act), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rise_i(pd_rise), .fall_i(pd_fall),
    .lvl_i(pd_lvl), .arm_o(arm), .swh_o(swh), .flg_o(flg), .ien_o(ien),
    .rdata_o(rdata_o));

  // armed hardware path acts on the synchronized low level directly
  assign shut_c = lrst_act | swh | (arm & ~pd_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      shut_rst_o <= 1'b0;
      irq_o      <= 1'b0;
      host_o     <= '0;
    end else begin
      shut_rst_o <= shut_c;
      irq_o      <= flg & ien;
      host_o     <= shut_c ? '0 : host_i;
    end
  end

  assert_lrst_shuts_R10: assert property (@(posedge clk) disable iff (rst)
    lrst_act |=> shut_rst_o);
  assert_mask_R11: assert property (@(posedge clk) disable iff (rst)
    shut_rst_o |-> (host_o == '0));
  assert_armed_low_R4: assert property (@(posedge clk) disable iff (rst)
    (arm && !pd_lvl) |=> shut_rst_o);
  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_o);
endmodule

// File: tb/lpc_shutdown_ctrl_tb.sv
module lpc_shutdown_ctrl_tb;
  logic clk = 0, rst = 1, pd_n = 1, lreset_n = 1, wr_en = 0, rd_en = 0;
  logic [3:0] wdata = 0;
  logic [4:0] rdata;
  logic [7:0] host_i = 0, host_o;
  logic shut, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpc_shutdown_ctrl u_dut (
    .clk(clk), .rst(rst), .pd_n_i(pd_n), .lreset_n_i(lreset_n),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .host_i(host_i), .host_o(host_o), .shut_rst_o(shut), .irq_o(irq));

  // {wr, wdata[3:0], pd, exp_read[4:0], exp_shut, exp_irq}
  localparam logic [12:0] VEC [15] = '{
    13'b1_0000_1_10000_0_0,
    13'b1_0010_1_10010_1_0,
    13'b1_0011_1_10001_0_0,
    13'b0_0000_0_00101_1_0,
    13'b0_0000_1_10100_0_0,
    13'b1_0010_1_10010_1_0,
    13'b0_0000_0_00110_1_0,
    13'b0_0000_1_10110_1_0,
    13'b1_1000_1_11000_0_0,
    13'b0_0000_0_01100_0_1,
    13'b0_0000_1_11100_0_1,
    13'b1_1001_1_11001_0_0,
    13'b0_0000_0_01101_1_1,
    13'b0_0000_1_11100_0_1,
    13'b1_1000_1_11000_0_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    wdata = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(output logic [4:0] v);
    rd_en = 1; @(negedge clk); rd_en = 0; v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] v;
    cyc(5); rst = 0; cyc(1);
    chk("R1 shut", shut, 0);
    chk("R1 irq", irq, 0);
    rd(v); chk("R1 read", v, 5'b10000);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i][12]) wr(VEC[i][11:8]);
      pd_n = VEC[i][7];
      cyc(6);
      chk($sformatf("R2/R4/R5 shut vec%0d", i), shut, VEC[i][1]);
      chk($sformatf("R8 irq vec%0d", i), irq, VEC[i][0]);
      rd(v);
      chk($sformatf("R3/R6/R7/R9 read vec%0d", i), v, VEC[i][6:2]);
    end

    // R7: clear without prior read is ignored
    pd_n = 0; cyc(6); pd_n = 1; cyc(6);
    wr(4'b1000); cyc(1);
    rd(v); chk("R7 no-read clear ignored", v[2], 1);
    wr(4'b1000); cyc(1);
    rd(v); chk("R7 clear after read", v[2], 0);

    // R10: LPC reset
    wr(4'b1010); pd_n = 0; cyc(6); pd_n = 1; cyc(6);
    lreset_n = 0; cyc(6);
    chk("R10 shut held", shut, 1);
    wr(4'b0011); cyc(6);
    chk("R10 shut still held", shut, 1);
    lreset_n = 1; cyc(6);
    chk("R10 shut released", shut, 0);
    rd(v); chk("R10 bits cleared, write ignored", v, 5'b11000);

    // R11: host masking
    host_i = 8'hA5; cyc(3);
    chk("R11 pass", host_o, 8'hA5);
    wr(4'b0010); cyc(2);
    chk("R11 masked", host_o, 8'h00);
    wr(4'b0000); cyc(2);
    chk("R11 pass again", host_o, 8'hA5);

    // R12: latency of armed shutdown through synchronizer
    wr(4'b0001); cyc(2);
    pd_n = 0;
    cyc(2); chk("R12 not yet at edge 2", shut, 0);
    cyc(1); chk("R12 shut at edge 3 (R4)", shut, 1);
    pd_n = 1; cyc(6);
    chk("R5 rise ends shutdown", shut, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule